// File: doc/BRIEF.md
# Parallel NOR flash command interpreter

This block models the device side of a 16-bit parallel NOR flash that takes unlock-prefixed command sequences over a synchronous word bus. A bus master drives select, write strobe, read strobe, a word address and write data. The block returns registered read data and a busy flag. A small array of flop-based words stands in for the flash cells. It is split into sectors of equal size, and every word reads all-ones after reset.

Writes are decoded by a command state machine. A two-write unlock prefix opens the command set: identifier readout, word program, sector erase, chip erase and an unlock-bypass mode. A query mode that needs no prefix reports the array geometry. Programming can only clear bits. While a program or erase is running, the busy flag is high, reads return a polling status instead of array data, and all writes are dropped. The program time and the erase time are parameters, counted in clock cycles.

Top module: `nor_flash_model`

## Requirements
- R1: After reset the block is in read-array mode, busy is low and every word reads 0xFFFF. Read data appears on bus_rdata in the cycle after a read strobe and holds until the next read.
- R2: A command is accepted only after the prefix 0xAA written to word 0x5555, then 0x55 written to word 0x2AAA. A wrong write in either prefix slot returns to read-array mode, so the writes that follow are not taken as commands. Command codes are compared on data bits 7:0.
- R3: Prefix then 0x90 at 0x5555 enters identifier mode. In that mode word 0 reads 0x00BF, word 1 reads 0x236D and other words read 0.
- R4: 0x98 written at word 0x55 in read-array mode enters query mode. Words 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059. Word 0x2C reads 1. Words 0x2D and 0x2E give the low and high byte of (sector count - 1). Words 0x2F and 0x30 give the low and high byte of the sector size in 256-byte units.
- R5: 0xF0 written to any address leaves identifier or query mode and returns to read-array mode.
- R6: Prefix, then 0xA0 at 0x5555, then a data write at the target stores the old word ANDed with the data. For example, 0x5555 followed by 0xAA55 on an erased word leaves 0x0055.
- R7: Prefix, 0x80 at 0x5555, prefix again, then 0x30 at any address sets every word of the sector holding that address to 0xFFFF. Other sectors keep their contents.
- R8: The same sequence with 0x10 at 0x5555 as the final write sets every word of the array to 0xFFFF.
- R9: busy rises in the cycle after the final write of a program or erase. It stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase.
- R10: While busy, a read returns bit 7 equal to the complement of bit 7 of the word being written (0 for an erase). Bit 6 inverts on each successive read and all other bits are 0. After busy falls, repeated reads return the same valid array data.
- R11: Every write that arrives while busy is high is ignored, including prefix and command writes.
- R12: Prefix then 0x20 at 0x5555 enters bypass mode. In bypass mode, 0xA0 at any address followed by a data write programs that word as in R6, and the block stays in bypass mode.
- R13: 0x00 written in bypass mode returns to read-array mode. After that, 0xA0 followed by a data write with no prefix changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Device select; strobes count only when high |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data or command code |
| bus_rdata | output | DATA_W | Registered read data or status |
| busy | output | 1 | High while a program or erase is running |

## Verification
The program function is tried three ways. Two successive patterns on one word show that programming is an AND and not an overwrite. A full sweep of every word in bypass mode, with two arithmetic patterns ANDed, checks that no two words alias and that the sector decode is right. A single word programmed with an unlocked prefix checks the normal path. Erase is checked against a word planted in the other sector, which separates a sector erase from a chip erase. The status reads during a program and during an erase separate the data-polling bit from the toggle bit. Writes made during busy, prefixes with a bad address, and a prefix-less program after bypass exit each carry a write that would change the array visibly if it were wrongly accepted.

// File: rtl/nor_pkg.sv
package nor_pkg;

   typedef enum logic [3:0] {
      ST_ARRAY,
      ST_UL1,
      ST_UL2,
      ST_ER1,
      ST_ER2,
      ST_ER3,
      ST_PROG,
      ST_ID,
      ST_CFI,
      ST_BYP,
      ST_BYP_PROG
   } cmd_st_e;

   typedef enum logic [1:0] {
      MD_ARRAY,
      MD_ID,
      MD_CFI
   } rd_mode_e;

   localparam logic [7:0] C_KEY0     = 8'hAA;
   localparam logic [7:0] C_KEY1     = 8'h55;
   localparam logic [7:0] C_IDENT    = 8'h90;
   localparam logic [7:0] C_QUERY    = 8'h98;
   localparam logic [7:0] C_EXIT     = 8'hF0;
   localparam logic [7:0] C_WRITE    = 8'hA0;
   localparam logic [7:0] C_ERASE    = 8'h80;
   localparam logic [7:0] C_SECT     = 8'h30;
   localparam logic [7:0] C_CHIP     = 8'h10;
   localparam logic [7:0] C_BYP_IN   = 8'h20;
   localparam logic [7:0] C_BYP_OUT  = 8'h00;

   localparam logic [15:0] K_MAKER  = 16'h00BF;
   localparam logic [15:0] K_DEVICE = 16'h236D;

endpackage

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
   parameter int ADDR_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_fire,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [7:0]           cmd,
   output logic                 prog_go,
   output logic                 sect_go,
   output logic                 chip_go,
   output nor_pkg::rd_mode_e    mode
);
   import nor_pkg::*;

   localparam logic [ADDR_W-1:0] A_KEY0  = ADDR_W'(16'h5555);
   localparam logic [ADDR_W-1:0] A_KEY1  = ADDR_W'(16'h2AAA);
   localparam logic [ADDR_W-1:0] A_QUERY = ADDR_W'(16'h0055);

   cmd_st_e st_q, st_d;

   logic at_k0, at_k1;
   assign at_k0 = (addr == A_KEY0);
   assign at_k1 = (addr == A_KEY1);

   always_comb begin
      st_d    = st_q;
      prog_go = 1'b0;
      sect_go = 1'b0;
      chip_go = 1'b0;
      if (wr_fire) begin
         unique case (st_q)
            ST_ARRAY: begin
               if (cmd == C_KEY0 && at_k0)               st_d = ST_UL1;
               else if (cmd == C_QUERY && addr == A_QUERY) st_d = ST_CFI;
            end
            ST_UL1: st_d = (cmd == C_KEY1 && at_k1) ? ST_UL2 : ST_ARRAY;
            ST_UL2: begin
               st_d = ST_ARRAY;
               if (at_k0) begin
                  case (cmd)
                     C_IDENT:  st_d = ST_ID;
                     C_WRITE:  st_d = ST_PROG;
                     C_ERASE:  st_d = ST_ER1;
                     C_BYP_IN: st_d = ST_BYP;
                     default:  st_d = ST_ARRAY;
                  endcase
               end
            end
            ST_ER1: st_d = (cmd == C_KEY0 && at_k0) ? ST_ER2 : ST_ARRAY;
            ST_ER2: st_d = (cmd == C_KEY1 && at_k1) ? ST_ER3 : ST_ARRAY;
            ST_ER3: begin
               st_d = ST_ARRAY;
               if (cmd == C_SECT)              sect_go = 1'b1;
               else if (cmd == C_CHIP && at_k0) chip_go = 1'b1;
            end
            ST_PROG: begin
               prog_go = 1'b1;
               st_d    = ST_ARRAY;
            end
            ST_ID, ST_CFI: begin
               if (cmd == C_EXIT) st_d = ST_ARRAY;
            end
            ST_BYP: begin
               if (cmd == C_WRITE)        st_d = ST_BYP_PROG;
               else if (cmd == C_BYP_OUT) st_d = ST_ARRAY;
            end
            ST_BYP_PROG: begin
               prog_go = 1'b1;
               st_d    = ST_BYP;
            end
            default: st_d = ST_ARRAY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_ARRAY;
      else        st_q <= st_d;
   end

   always_comb begin
      case (st_q)
         ST_ID:   mode = MD_ID;
         ST_CFI:  mode = MD_CFI;
         default: mode = MD_ARRAY;
      endcase
   end

   // R12: a bypass program returns to bypass mode, not read-array
   assert_byp_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BYP_PROG && wr_fire) |=> (st_q == ST_BYP));

   // R2: a bad second prefix write always falls back to read-array
   assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_UL1 && wr_fire && !at_k1) |=> (st_q == ST_ARRAY));

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
   parameter int PROG_CYCLES  = 6,
   parameter int ERASE_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_prog,
   input  logic start_erase,
   output logic busy
);
   localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (start_prog)       cnt_q <= CW'(PROG_CYCLES);
      else if (start_erase)      cnt_q <= CW'(ERASE_CYCLES);
      else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
   end

   assign busy = (cnt_q != '0);

   // R9: the count falls by one each cycle with no new start
   assert_busy_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start_prog && !start_erase) |=> (cnt_q == $past(cnt_q) - CW'(1)));

   // R9: a program start always leads to busy in the following cycle
   assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_prog |=> busy);

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
   parameter int DATA_W = 16,
   parameter int ARR_AW = 8,
   parameter int SECT_AW = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_go,
   input  logic               sect_go,
   input  logic               chip_go,
   input  logic [ARR_AW-1:0]  waddr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [ARR_AW-1:0]  raddr,
   output logic [DATA_W-1:0]  rword
);
   localparam int SEC_W  = ARR_AW - SECT_AW;
   localparam int NSECT  = 1 << SEC_W;
   localparam int NWORDS = 1 << SECT_AW;

   logic [DATA_W-1:0] sec_rd [NSECT];
   logic [SEC_W-1:0]  wsec, rsec;
   logic [SECT_AW-1:0] woff, roff;

   assign wsec = waddr[ARR_AW-1:SECT_AW];
   assign rsec = raddr[ARR_AW-1:SECT_AW];
   assign woff = waddr[SECT_AW-1:0];
   assign roff = raddr[SECT_AW-1:0];

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      logic [DATA_W-1:0] cells [NWORDS];
      logic hit, wipe;

      assign hit  = (wsec == SEC_W'(s));
      assign wipe = chip_go || (sect_go && hit);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) cells[w] <= '1;
         end else if (wipe) begin
            for (int w = 0; w < NWORDS; w++) cells[w] <= '1;
         end else if (prog_go && hit) begin
            cells[woff] <= cells[woff] & wdata;
         end
      end

      assign sec_rd[s] = cells[roff];

      // checker state for the program result
      logic [SECT_AW-1:0] chk_off_q;
      logic [DATA_W-1:0]  chk_exp_q;
      logic               chk_vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chk_vld_q <= 1'b0;
            chk_off_q <= '0;
            chk_exp_q <= '0;
         end else begin
            chk_vld_q <= prog_go && hit && !wipe;
            chk_off_q <= woff;
            chk_exp_q <= cells[woff] & wdata;
         end
      end

      // R6: a programmed word holds old AND new one cycle later
      assert_prog_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
         chk_vld_q |-> (cells[chk_off_q] == chk_exp_q));

      // R7: an erase leaves the first and last word of the sector all-ones
      assert_erase_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
         wipe |=> (cells[0] == '1 && cells[NWORDS-1] == '1));
   end

   assign rword = sec_rd[rsec];

endmodule

// File: rtl/nor_flash_model.sv
module nor_flash_model #(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 16,
   parameter int ARR_AW       = 8,
   parameter int SECT_AW      = 7,
   parameter int PROG_CYCLES  = 6,
   parameter int ERASE_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              busy
);
   import nor_pkg::*;

   localparam int NSECT     = 1 << (ARR_AW - SECT_AW);
   localparam int SECT_M1   = NSECT - 1;
   localparam int SECT_U256 = (1 << SECT_AW) * 2 / 256;

   if (DATA_W != 16) begin : g_bad_width
      $error("nor_flash_model: DATA_W must be 16");
   end
   if (ADDR_W < 15 || ARR_AW > ADDR_W) begin : g_bad_addr
      $error("nor_flash_model: ADDR_W must cover word 0x5555 and the array");
   end
   if (SECT_AW < 7 || SECT_AW >= ARR_AW) begin : g_bad_sect
      $error("nor_flash_model: sector must be >= 256 bytes and smaller than the array");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_time
      $error("nor_flash_model: busy times must be at least one cycle");
   end

   logic      wr_fire, rd_fire;
   logic      prog_go, sect_go, chip_go;
   rd_mode_e  mode;
   logic [DATA_W-1:0] arr_word;
   logic [DATA_W-1:0] rd_mux;
   logic      dq7_q, tgl_q;

   assign wr_fire = bus_sel && bus_wr && !busy;
   assign rd_fire = bus_sel && bus_rd;

   nor_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .addr    (bus_addr),
      .cmd     (bus_wdata[7:0]),
      .prog_go (prog_go),
      .sect_go (sect_go),
      .chip_go (chip_go),
      .mode    (mode)
   );

   nor_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_prog  (prog_go),
      .start_erase (sect_go || chip_go),
      .busy        (busy)
   );

   nor_cell_array #(.DATA_W(DATA_W), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .prog_go (prog_go),
      .sect_go (sect_go),
      .chip_go (chip_go),
      .waddr   (bus_addr[ARR_AW-1:0]),
      .wdata   (bus_wdata),
      .raddr   (bus_addr[ARR_AW-1:0]),
      .rword   (arr_word)
   );

   // status flops: polling bit latched at launch, toggle flips per busy read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq7_q <= 1'b0;
         tgl_q <= 1'b0;
      end else begin
         if (prog_go)                   dq7_q <= ~bus_wdata[7];
         else if (sect_go || chip_go)   dq7_q <= 1'b0;
         if (rd_fire && busy)           tgl_q <= ~tgl_q;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (busy) begin
         rd_mux[7] = dq7_q;
         rd_mux[6] = tgl_q;
      end else begin
         unique case (mode)
            MD_ID: begin
               if (bus_addr == ADDR_W'(0))      rd_mux = K_MAKER;
               else if (bus_addr == ADDR_W'(1)) rd_mux = K_DEVICE;
            end
            MD_CFI: begin
               case (bus_addr)
                  ADDR_W'(16'h10): rd_mux = DATA_W'(8'h51);
                  ADDR_W'(16'h11): rd_mux = DATA_W'(8'h52);
                  ADDR_W'(16'h12): rd_mux = DATA_W'(8'h59);
                  ADDR_W'(16'h2C): rd_mux = DATA_W'(1);
                  ADDR_W'(16'h2D): rd_mux = DATA_W'(SECT_M1 & 255);
                  ADDR_W'(16'h2E): rd_mux = DATA_W'((SECT_M1 >> 8) & 255);
                  ADDR_W'(16'h2F): rd_mux = DATA_W'(SECT_U256 & 255);
                  ADDR_W'(16'h30): rd_mux = DATA_W'((SECT_U256 >> 8) & 255);
                  default:         rd_mux = '0;
               endcase
            end
            default: rd_mux = arr_word;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bus_rdata <= '1;
      else if (rd_fire) bus_rdata <= rd_mux;
   end

   // R11: no operation is launched while one is running
   assert_no_launch_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_go || sect_go || chip_go) |-> !busy);

   // R10: back-to-back busy reads return opposite bit 6
   assert_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && busy && $past(rd_fire && busy)) |=> (bus_rdata[6] != $past(bus_rdata[6])));

   // R3: identifier word 0 in identifier mode
   assert_id_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !busy && mode == MD_ID && bus_addr == ADDR_W'(0)) |=> (bus_rdata == K_MAKER));

   // R1: read data holds when no read strobe is given
   assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> $stable(bus_rdata));

endmodule

// File: tb/nor_flash_model_tb_top.sv
module nor_flash_model_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ARR_AW  = 8;
   localparam int SECT_AW = 7;
   localparam int PROG_T  = 6;
   localparam int ERASE_T = 20;
   localparam int NWORDS  = 1 << ARR_AW;
   localparam int NSECT   = 1 << (ARR_AW - SECT_AW);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_addr = '0, bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        busy;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] model [NWORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   nor_flash_model #(.ARR_AW(ARR_AW), .SECT_AW(SECT_AW),
                     .PROG_CYCLES(PROG_T), .ERASE_CYCLES(ERASE_T)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [15:0] d);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic unlock();
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAA, 16'h0055);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic count_busy(output int c);
      c = 0;
      while (busy) begin
         c++;
         @(negedge clk);
      end
   endtask

   function automatic logic [15:0] pat_a(input int i);
      return 16'(i * 16'h9E37) ^ 16'h5A5A;
   endfunction

   function automatic logic [15:0] pat_b(input int i);
      return ~16'(i * 16'h01F3);
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] v, s0, s1;
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 busy after reset", {15'd0, busy}, 16'd0);
      rd(16'd0, v);               chk("R1 word 0 erased", v, 16'hFFFF);
      rd(16'(NWORDS-1), v);       chk("R1 last word erased", v, 16'hFFFF);
      @(negedge clk);
      chk("R1 read data holds", bus_rdata, 16'hFFFF);

      // R3 identifier mode, R5 exit
      unlock(); wr(16'h5555, 16'h0090);
      rd(16'd0, v); chk("R3 maker id", v, 16'h00BF);
      rd(16'd1, v); chk("R3 device id", v, 16'h236D);
      rd(16'd2, v); chk("R3 other id word", v, 16'h0000);
      wr(16'h0777, 16'h00F0);
      rd(16'd0, v); chk("R5 exit identifier", v, 16'hFFFF);

      // R4 query mode, R5 exit
      wr(16'h0055, 16'h0098);
      rd(16'h10, v); chk("R4 query Q", v, 16'h0051);
      rd(16'h11, v); chk("R4 query R", v, 16'h0052);
      rd(16'h12, v); chk("R4 query Y", v, 16'h0059);
      rd(16'h2C, v); chk("R4 region count", v, 16'd1);
      rd(16'h2D, v); chk("R4 sectors-1 low", v, 16'((NSECT - 1) & 255));
      rd(16'h2E, v); chk("R4 sectors-1 high", v, 16'(((NSECT - 1) >> 8) & 255));
      rd(16'h2F, v); chk("R4 size low", v, 16'((((1 << SECT_AW) * 2) / 256) & 255));
      rd(16'h30, v); chk("R4 size high", v, 16'(((((1 << SECT_AW) * 2) / 256) >> 8) & 255));
      wr(16'h1234, 16'h00F0);
      rd(16'd1, v); chk("R5 exit query", v, 16'hFFFF);

      // R6 program with R10 status reads
      unlock(); wr(16'h5555, 16'h00A0); wr(16'd5, 16'h5555);
      rd(16'd5, s0); rd(16'd5, s1);
      chk("R10 program status bits", s0 & 16'hFFBF, 16'h0080);
      chk("R10 program toggle", {15'd0, s0[6] ^ s1[6]}, 16'd1);
      wait_idle();
      rd(16'd5, s0); rd(16'd5, s1);
      chk("R10 stable after program", s1, s0);
      chk("R6 first program", s0, 16'h5555);
      unlock(); wr(16'h5555, 16'h00A0); wr(16'd5, 16'hAA55);
      count_busy(c);
      chk("R9 program busy length", 16'(c), 16'(PROG_T));
      rd(16'd5, v); chk("R6 program ANDs", v, 16'h0055);

      // R2 bad prefix aborts
      wr(16'h5555, 16'h00AA); wr(16'h1234, 16'h0055);
      wr(16'h5555, 16'h00A0); wr(16'd6, 16'h0000);
      chk("R2 no busy after bad prefix", {15'd0, busy}, 16'd0);
      rd(16'd6, v); chk("R2 bad prefix ignored", v, 16'hFFFF);
      wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055);
      wr(16'h5554, 16'h00A0); wr(16'd6, 16'h0000);
      rd(16'd6, v); chk("R2 command at wrong address", v, 16'hFFFF);

      // R11 writes ignored while busy
      unlock(); wr(16'h5555, 16'h00A0); wr(16'd7, 16'h00F0);
      wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
      wait_idle();
      wr(16'd8, 16'h0000);
      rd(16'd8, v); chk("R11 busy writes ignored", v, 16'hFFFF);
      rd(16'd7, v); chk("R11 running program result", v, 16'h00F0);

      // R7 sector erase
      unlock(); wr(16'h5555, 16'h00A0); wr(16'd130, 16'h1234);
      wait_idle();
      unlock(); wr(16'h5555, 16'h0080); unlock(); wr(16'd3, 16'h0030);
      rd(16'd3, s0); rd(16'd3, s1);
      chk("R10 erase status bits", s0 & 16'hFFBF, 16'h0000);
      chk("R10 erase toggle", {15'd0, s0[6] ^ s1[6]}, 16'd1);
      wait_idle();
      rd(16'd5, v);   chk("R7 sector word 5 erased", v, 16'hFFFF);
      rd(16'd7, v);   chk("R7 sector word 7 erased", v, 16'hFFFF);
      rd(16'd127, v); chk("R7 sector end erased", v, 16'hFFFF);
      rd(16'd130, v); chk("R7 other sector kept", v, 16'h1234);

      // R8 chip erase, R9 erase busy length
      unlock(); wr(16'h5555, 16'h0080); unlock(); wr(16'h5555, 16'h0010);
      count_busy(c);
      chk("R9 erase busy length", 16'(c), 16'(ERASE_T));
      rd(16'd130, v); chk("R8 chip erase", v, 16'hFFFF);

      // R12 bypass sweep over every word, two ANDed patterns
      for (int i = 0; i < NWORDS; i++) model[i] = 16'hFFFF;
      unlock(); wr(16'h5555, 16'h0020);
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < NWORDS; i++) begin
            logic [15:0] d;
            d = (p == 0) ? pat_a(i) : pat_b(i);
            wr(16'(i * 37 + 11), 16'h00A0);
            wr(16'(i), d);
            model[i] = model[i] & d;
            wait_idle();
         end
      end

      // R13 exit bypass, then prefix-less program is ignored
      wr(16'd0, 16'h0000);
      wr(16'd0, 16'h00A0); wr(16'd0, 16'h0000);
      chk("R13 no busy after exit", {15'd0, busy}, 16'd0);
      rd(16'd0, v); chk("R13 word 0 untouched", v, model[0]);
      for (int i = 0; i < NWORDS; i++) begin
         rd(16'(i), v);
         chk("R12 bypass sweep word", v, model[i]);
      end

      summary();
      $finish;
   end
endmodule